// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synchronous static RAM with an 18-bit data path split into two 9-bit byte lanes. Every selected clock carries one transfer, and reads and writes can alternate on consecutive clocks with no idle cycle. To make that possible, write data is presented a fixed number of clocks after its write command, so the data bus timing for writes matches the read-data timing. A strap input picks one of two read modes. In flow-through mode, read data appears in the clock after the command and write data follows its command by one clock. In pipelined mode, read data passes through an output register and appears one clock later, and write data follows its command by two clocks.

Each write lane carries a parity bit, which is checked with even or odd sense. Lanes can be masked. An advance input steps a two-bit burst counter in linear or interleaved order. An output enable gates the read drivers combinationally at any time.

The bus has no back-pressure. The three select inputs together act as the valid qualifier. Every selected cycle is accepted, and a consumer of read data must take it in the cycle it is driven, since the block never stalls. High impedance is represented by `dout_oe` low, with `dout` forced to zero.

Top module: `nbt_sram`

## Requirements
- R1: A cycle is selected only when `sel_a`, `sel_b` and `sel_c` are all 1 at the rising edge. A cycle that is not selected performs no access, and `dout_oe` is 0 at the point where a read issued in that cycle would have been driven.
- R2: In flow-through mode (`pipe_mode`=0), a read sampled at edge k drives `dout` with `dout_oe`=1 between edges k and k+1. In pipelined mode (`pipe_mode`=1), the same read is driven between edges k+1 and k+2.
- R3: Write data is sampled on `din` at edge k+1 in flow-through mode and at edge k+2 in pipelined mode, for a write command at edge k. `be[0]` enables lane 0 (bits 8:0) and `be[1]` enables lane 1 (bits 17:9), and both enables are sampled with the command. A disabled lane keeps its stored value. A write cycle never drives `dout_oe`.
- R4: Reads and writes may alternate on consecutive clocks. A read always returns the newest data, including data from a write whose data phase falls in the same edge that loads the pipelined output register.
- R5: With `adv`=1 in a selected cycle, the block continues the current burst. It ignores `addr` and `we`, repeats the operation type of the burst start, and keeps the upper six address bits. The low two bits are the start value plus n modulo 4 when `burst_interleave`=0, or the start value XOR n when it is 1, where n is the count of advances since the start (1, 2, 3, then 0 again). With `adv`=0, a selected cycle starts a new burst at `addr`.
- R6: At the edge where write data is sampled, `par_err[l]` is set for the following cycle if lane l is enabled and the XOR of its 9 bits is not equal to `parity_odd`. The flag is 0 otherwise. The write completes regardless of the parity result.
- R7: `oe`=0 forces `dout_oe` to 0 immediately, without waiting for a clock. `dout` is zero whenever `dout_oe` is 0.
- R8: A cycle that is not selected leaves the burst state unchanged. A later advance continues from the last burst address.
- R9: While `rst_n` is low, and immediately after it is released, `dout_oe` and `par_err` are 0. The burst state after reset is start address 0 with a read operation type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | Strap: 1 pipelined, 0 flow-through |
| burst_interleave | input | 1 | Strap: 1 interleaved burst order, 0 linear |
| parity_odd | input | 1 | Parity sense: 1 odd, 0 even |
| sel_a | input | 1 | Select input A, active high |
| sel_b | input | 1 | Select input B, active high |
| sel_c | input | 1 | Select input C, active high |
| adv | input | 1 | Continue the current burst |
| we | input | 1 | 1 write, 0 read (for burst starts) |
| addr | input | 8 | Word address |
| be | input | 2 | Lane write enables |
| din | input | 18 | Write data with a parity bit in each lane's top bit |
| oe | input | 1 | Output enable, combinational |
| dout | output | 18 | Read data |
| dout_oe | output | 1 | Read drivers active |
| par_err | output | 2 | Per-lane write parity error flag |

## Verification
If a command stage register is stale or shifted, the fault appears on `dout_oe` at the first read or deselect. The driving window lands one clock early or late, which is visible within two clocks of the command. If the write-commit stage is wrong, or forwarding is missing, a read placed directly after a write to the same word returns old data in the same clock the output register loads. If the burst counter has advanced wrongly, or has advanced on a deselect, the next advance reads the wrong word. Parity sense or lane-mask faults show on `par_err` one clock after the data edge.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned LANES   = 2;
  localparam int unsigned LANE_W  = 9;
  localparam int unsigned BURST_W = 2;
  localparam int unsigned DATA_W  = LANES * LANE_W;
  localparam int unsigned DEPTH   = 2 ** ADDR_W;

  typedef struct packed {
    logic              live;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  be;
  } cmd_t;

  // 1 when the lane's 9 bits do not have the requested parity sense
  function automatic logic lane_bad(input logic [LANE_W-1:0] v, input logic odd_sense);
    return (^v) ^ odd_sense;
  endfunction
endpackage

// File: rtl/nbt_burst.sv
module nbt_burst
  import nbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              adv_i,
  input  logic              we_i,
  input  logic              interleave_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] res_addr_o,
  output logic              res_wr_o
);
  logic [ADDR_W-BURST_W-1:0] hi_q;
  logic [BURST_W-1:0]        base_q;
  logic [BURST_W-1:0]        cnt_q;
  logic [BURST_W-1:0]        cnt_nx;
  logic                      op_q;

  assign cnt_nx = cnt_q + BURST_W'(1);

  always_comb begin
    if (adv_i) begin
      res_addr_o = {hi_q, interleave_i ? (base_q ^ cnt_nx) : (base_q + cnt_nx)};
      res_wr_o   = op_q;
    end else begin
      res_addr_o = addr_i;
      res_wr_o   = we_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      op_q   <= 1'b0;
    end else if (sel_i) begin
      if (adv_i) begin
        cnt_q <= cnt_nx;
      end else begin
        hi_q   <= addr_i[ADDR_W-1:BURST_W];
        base_q <= addr_i[BURST_W-1:0];
        cnt_q  <= '0;
        op_q   <= we_i;
      end
    end
  end

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i && adv_i && !interleave_i && $past(sel_i) && $past(!interleave_i) && $past(rst_n)
    |-> res_addr_o[BURST_W-1:0] == $past(res_addr_o[BURST_W-1:0]) + BURST_W'(1));

  // R5
  burst_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i && adv_i && $past(sel_i) && $past(rst_n)
    |-> res_addr_o[ADDR_W-1:BURST_W] == $past(res_addr_o[ADDR_W-1:BURST_W]));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> $stable(cnt_q) && $stable(base_q) && $stable(op_q) && $stable(hi_q));
endmodule

// File: rtl/nbt_stages.sv
module nbt_stages
  import nbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd_i,
  output cmd_t s1_o,
  output cmd_t s2_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_o <= '0;
      s2_o <= '0;
    end else begin
      s1_o <= cmd_i;
      s2_o <= s1_o;
    end
  end
endmodule

// File: rtl/nbt_array.sv
module nbt_array
  import nbt_pkg::*;
(
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANES-1:0]  wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en_i && wr_be_i[l])
        mem[wr_addr_i][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              burst_interleave,
  input  logic              parity_odd,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              sel_c,
  input  logic              adv,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] din,
  input  logic              oe,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic [LANES-1:0]  par_err
);
  logic              sel;
  logic [ADDR_W-1:0] res_addr;
  logic              res_wr;
  cmd_t              cmd_in;
  cmd_t              s1;
  cmd_t              s2;
  cmd_t              commit;
  logic              commit_en;
  logic [DATA_W-1:0] rd_data;
  logic              fwd_hit;
  logic [DATA_W-1:0] merged;
  logic              rd_s1;
  logic              q_live;
  logic [DATA_W-1:0] q_data;
  logic              lat_live;
  logic [DATA_W-1:0] lat_data;

  assign sel = sel_a & sel_b & sel_c;

  nbt_burst u_burst (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_i        (sel),
    .adv_i        (adv),
    .we_i         (we),
    .interleave_i (burst_interleave),
    .addr_i       (addr),
    .res_addr_o   (res_addr),
    .res_wr_o     (res_wr)
  );

  always_comb begin
    cmd_in.live = sel;
    cmd_in.wr   = res_wr;
    cmd_in.addr = res_addr;
    cmd_in.be   = be;
  end

  nbt_stages u_stages (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_i (cmd_in),
    .s1_o  (s1),
    .s2_o  (s2)
  );

  // late-write commit point: one stage back in flow-through, two in pipelined
  assign commit    = pipe_mode ? s2 : s1;
  assign commit_en = commit.live & commit.wr;

  nbt_array u_array (
    .clk       (clk),
    .wr_en_i   (commit_en),
    .wr_addr_i (commit.addr),
    .wr_be_i   (commit.be),
    .wr_data_i (din),
    .rd_addr_i (s1.addr),
    .rd_data_o (rd_data)
  );

  // pipelined: a write one stage ahead commits on the edge that loads the output register
  assign fwd_hit = s2.live & s2.wr & (s2.addr == s1.addr);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      merged[l*LANE_W +: LANE_W] = (fwd_hit && s2.be[l]) ? din[l*LANE_W +: LANE_W]
                                                         : rd_data[l*LANE_W +: LANE_W];
    end
  end

  assign rd_s1 = s1.live & ~s1.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_live <= 1'b0;
      q_data <= '0;
    end else begin
      q_live <= rd_s1;
      if (rd_s1) q_data <= merged;
    end
  end

  assign lat_live = pipe_mode ? q_live : rd_s1;
  assign lat_data = pipe_mode ? q_data : rd_data;
  assign dout_oe  = oe & lat_live;
  assign dout     = dout_oe ? lat_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_err <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        par_err[l] <= commit_en & commit.be[l] & lane_bad(din[l*LANE_W +: LANE_W], parity_odd);
    end
  end

  // R7
  always_comb begin
    oe_gate_chk: assert (oe || !dout_oe);
  end

  // R6
  par_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|par_err) |-> $past(commit_en));

  // R1
  flow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_mode && !sel |=> !dout_oe);

  // R1
  pipe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_mode && !sel |=> ##1 !dout_oe);

  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_mode && sel && res_wr |=> !dout_oe);

  // R4
  forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_mode && rd_s1 && fwd_hit && (&s2.be) |=> !dout_oe || (dout == $past(din)));
endmodule

// File: tb/sim_nbt_sram.sv
module sim_nbt_sram;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pipe_mode;
  logic        burst_interleave;
  logic        parity_odd;
  logic        sel_a, sel_b, sel_c;
  logic        adv;
  logic        we;
  logic [7:0]  addr;
  logic [1:0]  be;
  logic [17:0] din;
  logic        oe;
  logic [17:0] dout;
  logic        dout_oe;
  logic [1:0]  par_err;

  always #5 clk = ~clk;

  nbt_sram u0 (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_interleave(burst_interleave),
    .parity_odd(parity_odd), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .adv(adv),
    .we(we), .addr(addr), .be(be), .din(din), .oe(oe), .dout(dout), .dout_oe(dout_oe),
    .par_err(par_err)
  );

  int checks = 0;
  int fails = 0;
  int unsigned ecount = 0;
  int unsigned seed_dummy;
  bit oe_rand = 0;

  logic [17:0] mm [256];
  bit          sv [4];
  logic [7:0]  sa [4];
  logic [1:0]  sb [4];
  logic [17:0] sd [4];

  logic [5:0] m_hi;
  logic [1:0] m_base, m_cnt;
  bit         m_op;

  int         prev_kind;
  logic [7:0] prev_addr;
  string      prev_tag;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] mk_data(input logic [1:0] bad);
    logic [17:0] r;
    logic [7:0]  d8;
    for (int l = 0; l < 2; l++) begin
      d8 = 8'($urandom);
      r[l*9 +: 9] = {(^d8) ^ parity_odd ^ bad[l], d8};
    end
    return r;
  endfunction

  task automatic step(input bit s, input bit a_n, input bit w, input logic [7:0] a,
                      input logic [1:0] b, input logic [1:0] bad, input string tag);
    int          slot, k, k2, lat, kind, okind;
    logic [7:0]  ra, oaddr;
    logic [1:0]  eperr;
    logic [17:0] ev;
    bit          edrv;
    string       otag;
    lat = pipe_mode ? 2 : 1;
    @(negedge clk);
    k = int'($urandom % 3);
    sel_a = s || (k != 0);
    sel_b = s || (k != 1);
    sel_c = s || (k != 2);
    adv = a_n; we = w; addr = a; be = b;
    oe = oe_rand ? ($urandom % 8 != 0) : 1'b1;
    slot = int'(ecount % 4);
    din = sv[slot] ? sd[slot] : 18'($urandom);
    kind = 0;
    ra = a;
    if (s) begin
      if (!a_n) begin
        m_hi = a[7:2]; m_base = a[1:0]; m_cnt = 2'd0; m_op = w;
      end else begin
        m_cnt = m_cnt + 2'd1;
      end
      ra = {m_hi, burst_interleave ? (m_base ^ m_cnt) : (m_base + m_cnt)};
      kind = m_op ? 2 : 1;
      if (m_op) begin
        k2 = int'((ecount + lat) % 4);
        sv[k2] = 1'b1; sa[k2] = ra; sb[k2] = b; sd[k2] = mk_data(bad);
      end
    end
    @(posedge clk);
    #1;
    eperr = 2'b00;
    if (sv[slot]) begin
      for (int l = 0; l < 2; l++) begin
        if (sb[slot][l]) begin
          mm[sa[slot]][l*9 +: 9] = sd[slot][l*9 +: 9];
          eperr[l] = (^sd[slot][l*9 +: 9]) ^ parity_odd;
        end
      end
      sv[slot] = 1'b0;
    end
    chk("R6 parity flag", 32'(par_err), 32'(eperr));
    if (pipe_mode) begin
      okind = prev_kind; oaddr = prev_addr; otag = prev_tag;
    end else begin
      okind = kind; oaddr = ra; otag = tag;
    end
    if (okind == 0) otag = "R1 deselected cycle";
    else if (okind == 2) otag = "R3 write cycle quiet";
    edrv = (okind == 1) && oe;
    ev = edrv ? mm[oaddr] : 18'd0;
    chk(otag, 32'({dout_oe, dout}), 32'({edrv, ev}));
    prev_kind = kind; prev_addr = ra; prev_tag = tag;
    ecount++;
  endtask

  task automatic do_reset(input bit pm, input bit il, input bit od);
    @(negedge clk);
    rst_n = 1'b0;
    sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b0;
    pipe_mode = pm; burst_interleave = il; parity_odd = od;
    repeat (3) @(negedge clk);
    chk("R9 output during reset", 32'({dout_oe, dout}), 32'd0);
    rst_n = 1'b1;
    #1;
    chk("R9 output after reset", 32'({dout_oe, dout}), 32'd0);
    chk("R9 flag after reset", 32'(par_err), 32'd0);
    m_hi = '0; m_base = '0; m_cnt = '0; m_op = 1'b0;
    prev_kind = 0;
    for (int i = 0; i < 4; i++) sv[i] = 1'b0;
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++)
      step($urandom % 8 != 0, $urandom % 4 == 0, 1'($urandom), 8'h30 + 8'($urandom % 16),
           2'($urandom), {1'($urandom % 8 == 0), 1'($urandom % 8 == 0)}, "R2 random mix");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd4711);
    rst_n = 1'b0; oe = 1'b1; adv = 1'b0; we = 1'b0; addr = '0; be = '0; din = '0;
    sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b0;
    pipe_mode = 1'b0; burst_interleave = 1'b0; parity_odd = 1'b0;
    for (int i = 0; i < 256; i++) mm[i] = '0;

    // phase A: flow-through, linear, even parity
    do_reset(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 256; i++) step(1, 0, 1, 8'(i), 2'b11, 2'b00, "R3 fill");
    step(1, 0, 1, 8'h50, 2'b11, 2'b00, "R4 write");
    step(1, 0, 0, 8'h50, 2'b11, 2'b00, "R4 read right after write");
    step(1, 0, 1, 8'h51, 2'b11, 2'b00, "R4 write");
    step(1, 0, 0, 8'h50, 2'b00, 2'b00, "R4 alternate read");
    step(1, 0, 1, 8'h51, 2'b01, 2'b00, "R3 lane mask write");
    step(1, 0, 0, 8'h51, 2'b00, 2'b00, "R3 lane mask readback");
    step(1, 0, 1, 8'h52, 2'b11, 2'b01, "R6 bad lane0");
    step(1, 0, 1, 8'h53, 2'b10, 2'b11, "R6 masked bad lane");
    step(1, 0, 0, 8'h52, 2'b00, 2'b00, "R6 write completes");
    step(1, 0, 0, 8'h62, 2'b00, 2'b00, "R5 burst start");
    step(0, 1, 0, 8'h00, 2'b00, 2'b00, "R8 gap");
    step(1, 1, 1, 8'hff, 2'b00, 2'b00, "R8 resume after gap");
    step(1, 1, 1, 8'hff, 2'b00, 2'b00, "R5 linear wrap");
    step(1, 1, 0, 8'hff, 2'b00, 2'b00, "R5 linear");
    step(1, 0, 1, 8'h70, 2'b11, 2'b00, "R5 write burst start");
    step(1, 1, 0, 8'hff, 2'b11, 2'b00, "R5 write burst advance");
    step(1, 0, 0, 8'h71, 2'b00, 2'b00, "R5 write burst readback");
    step(1, 0, 0, 8'h40, 2'b00, 2'b00, "R2 flow read");
    oe = 1'b0;
    #1;
    chk("R7 oe low gates output", 32'({dout_oe, dout}), 32'd0);
    oe = 1'b1;
    #1;
    chk("R7 oe high restores output", 32'({dout_oe, dout}), 32'({1'b1, mm[8'h40]}));
    oe_rand = 1;
    random_run(600);
    oe_rand = 0;
    repeat (3) step(0, 0, 0, 8'h00, 2'b00, 2'b00, "R1 idle");

    // phase B: pipelined, interleaved, odd parity
    do_reset(1'b1, 1'b1, 1'b1);
    step(1, 1, 1, 8'hff, 2'b00, 2'b00, "R9 burst origin");
    step(1, 0, 1, 8'h55, 2'b11, 2'b00, "R4 pipe write");
    step(1, 0, 0, 8'h55, 2'b00, 2'b00, "R4 forwarded read");
    step(1, 0, 1, 8'h56, 2'b10, 2'b00, "R4 partial write");
    step(1, 0, 0, 8'h56, 2'b00, 2'b00, "R4 partial forward");
    step(1, 0, 1, 8'h57, 2'b11, 2'b10, "R6 odd sense bad lane1");
    step(1, 0, 0, 8'h55, 2'b00, 2'b00, "R4 alternate read");
    step(1, 0, 0, 8'h66, 2'b00, 2'b00, "R5 interleave start");
    step(1, 1, 0, 8'h00, 2'b00, 2'b00, "R5 interleave step1");
    step(0, 1, 0, 8'h00, 2'b00, 2'b00, "R8 gap");
    step(1, 1, 0, 8'h00, 2'b00, 2'b00, "R5 interleave step2");
    step(1, 1, 0, 8'h00, 2'b00, 2'b00, "R5 interleave step3");
    step(1, 0, 0, 8'h57, 2'b00, 2'b00, "R6 write completes");
    oe_rand = 1;
    random_run(600);
    oe_rand = 0;
    repeat (3) step(0, 0, 0, 8'h00, 2'b00, 2'b00, "R1 idle");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule